// File: doc/BRIEF.md
# Converter Calibration and Filter-Settling Sequencer

This block is the control core that sits behind the 8-bit setup register of a delta-sigma converter. A host writes and reads the setup byte through a plain parallel port. The block watches an abstract update tick, which pulses once for each filter output period. From these inputs it decides when a fresh conversion word goes into the data register, and when the data-ready flag rises or falls. It runs one-step calibrations and latches the offset and full-scale coefficients from a sampled filter result. The gain, polarity and buffer fields are only stored and exported.

A synchronization bit holds the filter and calibration control in reset. When that bit is cleared, the block waits a fixed number of update ticks for the filter to settle before it loads the first word. A calibration clears its own mode field when it finishes, so a host that reads the register back can see the calibration is over.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset, the setup byte reads 0x01, data-ready is high, the load strobe is low and both coefficient registers hold zero.
- R2: A write stores the whole byte and a read returns the live value. The layout is bits [7:6] mode, [5:3] gain code, [2] unipolar select (1 = unipolar, 0 = bipolar) and [1] buffer enable. Bit [0] is the sync bit. The exported gain factor is 2 to the power of the gain code.
- R3: While the sync bit is 1, update ticks are ignored: no word is loaded and no coefficient is latched. Setting the sync bit never raises data-ready when it is low.
- R4: In normal mode (mode 00), once the sync bit is 0, the first word loads on the third update tick. Every later tick loads another word.
- R5: Each word load drives data-ready low.
- R6: Writing a non-zero mode with the sync bit at 0 starts a calibration. Data-ready is high on the second clock edge after the write.
- R7: Self-calibration (mode 01) runs two steps of three ticks each. The first step selects the shorted source (src_sel 1) and latches the offset coefficient. The second step selects the internal reference (src_sel 2) and latches the full-scale coefficient.
- R8: Zero-scale system calibration (mode 10) and full-scale system calibration (mode 11) each run a single three-tick step on the analog input (src_sel 0). The step latches the offset coefficient or the full-scale coefficient respectively.
- R9: When a calibration finishes, the mode field returns to 00 by itself. Data-ready stays high until the next update tick loads a word.
- R10: A mode write during a calibration restarts the sequence. A non-zero mode starts that calibration from its first step. Mode 00 aborts the calibration and begins a fresh three-tick settling period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Setup register write strobe |
| wr_data | input | 8 | Setup byte to write |
| rd_data | output | 8 | Live setup byte |
| upd_tick | input | 1 | One pulse per filter output period |
| filt_result | input | DATA_W | Sampled filter result |
| data_load | output | 1 | Strobe that loads a new word into the data register |
| data_rdy | output | 1 | Data-ready flag, low when a fresh word is held |
| offset_coef | output | DATA_W | Latched offset coefficient |
| fullscale_coef | output | DATA_W | Latched full-scale coefficient |
| src_sel | output | 2 | Input source select: 0 analog input, 1 shorted, 2 reference |
| gain_factor | output | 8 | Gain factor, 2 to the power of the code |
| unipolar | output | 1 | Unipolar coding selected |
| buf_en | output | 1 | Input buffer enable |

## Verification
The bench sweeps every combination of gain code, polarity and buffer setting with the sync bit held at 1. Each combination checks the readback byte and the exported fields, and confirms that the update ticks in between load nothing. It then runs all three calibration modes with a distinct filter value for each step. Because each value is different, the bench can tell which coefficient register was latched and on which tick. The bench also checks the source select in each step. Finally, it checks the ordering cases: a restart in the middle of a step, an abort back to normal mode, and setting the sync bit while data-ready is low. These confirm that the tick count restarts and that the data-ready flag is preserved.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_SELF = 2'd1,
        MODE_ZSYS = 2'd2,
        MODE_FSYS = 2'd3
    } cal_mode_e;

    typedef struct packed {
        cal_mode_e  mode;
        logic [2:0] gain;
        logic       unipolar;
        logic       buf_en;
        logic       fsync;
    } setup_t;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_CONV   = 3'd2,
        ST_ZERO   = 3'd3,
        ST_FULL   = 3'd4,
        ST_FIN    = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_INPUT = 2'd0,
        SRC_SHORT = 2'd1,
        SRC_REF   = 2'd2
    } src_sel_e;

    localparam setup_t SETUP_RESET = '{
        mode:     MODE_NORM,
        gain:     3'd0,
        unipolar: 1'b0,
        buf_en:   1'b0,
        fsync:    1'b1
    };

endpackage

// File: rtl/adc_setup_regs.sv
module adc_setup_regs
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       cal_done,
    output setup_t     cfg_o,
    output logic       restart_o
);

    typedef struct packed {
        setup_t cfg;
        logic   restart;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.restart = 1'b0;
        if (cal_done) begin
            r_d.cfg.mode = MODE_NORM;
        end
        if (wr_en) begin
            r_d.cfg     = setup_t'(wr_data);
            r_d.restart = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cfg: SETUP_RESET, restart: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o     = r_q.cfg;
    assign restart_o = r_q.restart;

    // R2: a written byte is what the register holds afterwards
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_o == $past(wr_data)));

    // R9: a finished calibration with no competing write leaves mode 00
    a_r9_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !wr_en) |=> (cfg_o.mode == MODE_NORM));

endmodule

// File: rtl/adc_tick_counter.sv
module adc_tick_counter #(
    parameter int unsigned SETTLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);

    localparam int unsigned CW = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(SETTLE_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last = tick && (cnt_q == LAST_VAL);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = (cnt_q == LAST_VAL) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: the tick count never runs past the settling length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL);

endmodule

// File: rtl/adc_cal_fsm.sv
module adc_cal_fsm
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cal_mode_e  mode,
    input  logic       fsync,
    input  logic       restart,
    input  logic       tick,
    input  logic       cnt_last,
    output logic       cnt_clr,
    output logic       data_load,
    output logic       lat_off,
    output logic       lat_fs,
    output logic       cal_done,
    output logic       data_rdy,
    output logic [1:0] src_sel
);

    typedef struct packed {
        seq_state_e state;
        logic       rdy;
    } fsm_t;

    fsm_t s_d, s_q;

    logic in_cal;
    logic start_cal;
    logic go_settle;

    assign in_cal = (s_q.state == ST_ZERO) || (s_q.state == ST_FULL) ||
                    (s_q.state == ST_FIN);

    assign start_cal = !fsync && (mode != MODE_NORM) &&
                       ((s_q.state == ST_HOLD) || restart);
    assign go_settle = !fsync && (mode == MODE_NORM) &&
                       ((s_q.state == ST_HOLD) || (restart && in_cal));

    always_comb begin
        s_d       = s_q;
        cnt_clr   = 1'b0;
        data_load = 1'b0;
        lat_off   = 1'b0;
        lat_fs    = 1'b0;
        cal_done  = 1'b0;
        if (fsync) begin
            s_d.state = ST_HOLD;
            cnt_clr   = 1'b1;
        end else if (start_cal) begin
            s_d.state = (mode == MODE_FSYS) ? ST_FULL : ST_ZERO;
            s_d.rdy   = 1'b1;
            cnt_clr   = 1'b1;
        end else if (go_settle) begin
            s_d.state = ST_SETTLE;
            cnt_clr   = 1'b1;
        end else begin
            unique case (s_q.state)
                ST_SETTLE: begin
                    if (cnt_last) begin
                        s_d.state = ST_CONV;
                        s_d.rdy   = 1'b0;
                        data_load = 1'b1;
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        s_d.rdy   = 1'b0;
                        data_load = 1'b1;
                    end
                end
                ST_ZERO: begin
                    if (cnt_last) begin
                        lat_off = 1'b1;
                        cnt_clr = 1'b1;
                        if (mode == MODE_SELF) begin
                            s_d.state = ST_FULL;
                        end else begin
                            s_d.state = ST_FIN;
                            cal_done  = 1'b1;
                        end
                    end
                end
                ST_FULL: begin
                    if (cnt_last) begin
                        lat_fs    = 1'b1;
                        cnt_clr   = 1'b1;
                        cal_done  = 1'b1;
                        s_d.state = ST_FIN;
                    end
                end
                ST_FIN: begin
                    if (tick) begin
                        s_d.state = ST_CONV;
                        s_d.rdy   = 1'b0;
                        data_load = 1'b1;
                    end
                end
                default: begin
                    s_d.state = ST_HOLD;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_HOLD, rdy: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        src_sel = SRC_INPUT;
        if (mode == MODE_SELF) begin
            if (s_q.state == ST_ZERO) begin
                src_sel = SRC_SHORT;
            end else if (s_q.state == ST_FULL) begin
                src_sel = SRC_REF;
            end
        end
    end

    assign data_rdy = s_q.rdy;

    // R3: the sync bit blocks every load and latch
    a_r3_sync_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> (!data_load && !lat_off && !lat_fs));

    // R3: the sync bit never raises a low data-ready
    a_r3_sync_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !data_rdy) |=> !data_rdy);

    // R5: a word load drops data-ready
    a_r5_load_clears_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        data_load |=> !data_rdy);

    // R6: entering a calibration from outside one leaves data-ready high
    a_r6_start_raises_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cal && !$past(in_cal)) |-> data_rdy);

endmodule

// File: rtl/adc_coef_store.sv
module adc_coef_store #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_off,
    input  logic              lat_fs,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] offset_o,
    output logic [DATA_W-1:0] fullscale_o
);

    typedef struct packed {
        logic [DATA_W-1:0] off;
        logic [DATA_W-1:0] fs;
    } coef_t;

    coef_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (lat_off) begin
            c_d.off = sample;
        end
        if (lat_fs) begin
            c_d.fs = sample;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign offset_o    = c_q.off;
    assign fullscale_o = c_q.fs;

    // R7: the offset word moves only on an offset latch
    a_r7_offset_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_off |=> $stable(offset_o));

    // R8: the full-scale word moves only on a full-scale latch
    a_r8_fullscale_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_fs |=> $stable(fullscale_o));

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned SETTLE_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              upd_tick,
    input  logic [DATA_W-1:0] filt_result,
    output logic              data_load,
    output logic              data_rdy,
    output logic [DATA_W-1:0] offset_coef,
    output logic [DATA_W-1:0] fullscale_coef,
    output logic [1:0]        src_sel,
    output logic [7:0]        gain_factor,
    output logic              unipolar,
    output logic              buf_en
);

    localparam int unsigned GAIN_STEPS = 8;

    setup_t cfg;
    logic   restart;
    logic   cal_done;
    logic   cnt_clr;
    logic   cnt_last;
    logic   lat_off;
    logic   lat_fs;

    adc_setup_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cal_done  (cal_done),
        .cfg_o     (cfg),
        .restart_o (restart)
    );

    adc_tick_counter #(
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (upd_tick),
        .last  (cnt_last)
    );

    adc_cal_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cfg.mode),
        .fsync     (cfg.fsync),
        .restart   (restart),
        .tick      (upd_tick),
        .cnt_last  (cnt_last),
        .cnt_clr   (cnt_clr),
        .data_load (data_load),
        .lat_off   (lat_off),
        .lat_fs    (lat_fs),
        .cal_done  (cal_done),
        .data_rdy  (data_rdy),
        .src_sel   (src_sel)
    );

    adc_coef_store #(
        .DATA_W (DATA_W)
    ) u_coef (
        .clk         (clk),
        .rst_n       (rst_n),
        .lat_off     (lat_off),
        .lat_fs      (lat_fs),
        .sample      (filt_result),
        .offset_o    (offset_coef),
        .fullscale_o (fullscale_coef)
    );

    generate
        for (genvar g = 0; g < GAIN_STEPS; g++) begin : g_gain
            assign gain_factor[g] = (cfg.gain == 3'(g));
        end
    endgenerate

    assign rd_data  = cfg;
    assign unipolar = cfg.unipolar;
    assign buf_en   = cfg.buf_en;

    // R2: exactly one gain factor bit is ever set
    a_r2_gain_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gain_factor) == 1);

endmodule

// File: tb/adc_cal_sequencer_tb.sv
module adc_cal_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          upd_tick = 1'b0;
    logic [DW-1:0] filt_result = '0;
    logic          data_load;
    logic          data_rdy;
    logic [DW-1:0] offset_coef;
    logic [DW-1:0] fullscale_coef;
    logic [1:0]    src_sel;
    logic [7:0]    gain_factor;
    logic          unipolar;
    logic          buf_en;

    int checks = 0;
    int errors = 0;
    int loads  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_cal_sequencer #(.DATA_W(DW), .SETTLE_TICKS(3)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .upd_tick       (upd_tick),
        .filt_result    (filt_result),
        .data_load      (data_load),
        .data_rdy       (data_rdy),
        .offset_coef    (offset_coef),
        .fullscale_coef (fullscale_coef),
        .src_sel        (src_sel),
        .gain_factor    (gain_factor),
        .unipolar       (unipolar),
        .buf_en         (buf_en)
    );

    always @(posedge clk) begin
        if (rst_n && data_load) loads <= loads + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_setup(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            upd_tick = 1'b1;
            @(negedge clk);
            upd_tick = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_data", rd_data, 8'h01);
        check("R1 data_rdy", data_rdy, 1);
        check("R1 data_load", data_load, 0);
        check("R1 offset", offset_coef, 0);
        check("R1 fullscale", fullscale_coef, 0);

        // R3 ticks ignored while synced
        ticks(4);
        check("R3 no loads in sync", loads, 0);
        check("R3 rdy kept", data_rdy, 1);

        // R2 sweep of gain, polarity, buffer with sync held
        for (int g = 0; g < 8; g++) begin
            for (int p = 0; p < 4; p++) begin
                v = {2'b00, 3'(g), p[1], p[0], 1'b1};
                write_setup(v);
                check("R2 readback", rd_data, v);
                check("R2 gain factor", gain_factor, 32'(1 << g));
                check("R2 unipolar", unipolar, p[1]);
                check("R2 buffer", buf_en, p[0]);
                ticks(1);
            end
        end
        check("R3 no loads during sweep", loads, 0);

        // R4 settling, R5 load clears rdy
        write_setup(8'h00);
        ticks(2);
        check("R4 no load before third tick", loads, 0);
        check("R4 rdy high before load", data_rdy, 1);
        ticks(1);
        check("R4 first load on third tick", loads, 1);
        check("R5 rdy low after load", data_rdy, 0);
        ticks(2);
        check("R4 one load per tick", loads, 3);

        // R3 sync with rdy low keeps it low
        write_setup(8'h01);
        check("R3 rdy stays low", data_rdy, 0);
        base = loads;
        ticks(3);
        check("R3 no loads after sync", loads, base);
        check("R3 readback", rd_data, 8'h01);

        // R6, R7 self-calibration
        write_setup(8'h40);
        check("R6 rdy raised", data_rdy, 1);
        check("R7 shorted source", src_sel, 1);
        filt_result = 16'h1234;
        ticks(2);
        check("R7 offset not yet", offset_coef, 0);
        ticks(1);
        check("R7 offset latched", offset_coef, 16'h1234);
        check("R7 reference source", src_sel, 2);
        filt_result = 16'hBEEF;
        ticks(3);
        check("R7 fullscale latched", fullscale_coef, 16'hBEEF);
        check("R7 offset kept", offset_coef, 16'h1234);
        check("R9 mode cleared", rd_data, 8'h00);
        check("R9 rdy still high", data_rdy, 1);
        base = loads;
        ticks(1);
        check("R9 word after cal", loads, base + 1);
        check("R5 rdy low after cal word", data_rdy, 0);

        // R8 zero-scale system calibration, gain code 3
        write_setup(8'h98);
        check("R6 rdy raised zsys", data_rdy, 1);
        check("R8 analog source zsys", src_sel, 0);
        filt_result = 16'h0F0F;
        ticks(3);
        check("R8 offset latched", offset_coef, 16'h0F0F);
        check("R8 fullscale untouched", fullscale_coef, 16'hBEEF);
        check("R9 mode cleared zsys", rd_data, 8'h18);
        ticks(1);
        check("R5 rdy low after zsys", data_rdy, 0);

        // R8 full-scale system calibration, gain 4, unipolar
        write_setup(8'hE4);
        check("R8 analog source fsys", src_sel, 0);
        filt_result = 16'h7777;
        ticks(3);
        check("R8 fullscale latched", fullscale_coef, 16'h7777);
        check("R8 offset untouched", offset_coef, 16'h0F0F);
        check("R9 mode cleared fsys", rd_data, 8'h24);

        // R10 restart mid-step
        write_setup(8'h80);
        filt_result = 16'h1111;
        ticks(2);
        write_setup(8'h40);
        check("R10 rdy high on restart", data_rdy, 1);
        check("R10 shorted after restart", src_sel, 1);
        filt_result = 16'h2222;
        ticks(2);
        check("R10 tick count restarted", offset_coef, 16'h0F0F);
        ticks(1);
        check("R10 offset after restart", offset_coef, 16'h2222);
        filt_result = 16'h3333;
        ticks(3);
        check("R10 fullscale after restart", fullscale_coef, 16'h3333);
        check("R10 mode cleared", rd_data, 8'h00);
        ticks(1);

        // R10 abort back to normal mode
        write_setup(8'hC0);
        filt_result = 16'h4444;
        ticks(1);
        write_setup(8'h00);
        base = loads;
        ticks(2);
        check("R10 abort no load yet", loads, base);
        check("R10 abort fullscale kept", fullscale_coef, 16'h3333);
        ticks(1);
        check("R10 abort load on third tick", loads, base + 1);
        check("R10 abort rdy low", data_rdy, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule